// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block brings up four supply rails one after another and takes them down again in the opposite order. A request input asks for the rails to be up (high) or down (low). For every rail there is a power-good input that reports the rail is above its under-voltage limit. All timing comes from cycle counts held in registers: one step delay per rail, a common blanking window, a fault hold time and a request-low timeout.

On power-up the controller waits the step delay of rail 0, then enables rail 0 and opens a blanking window. The rail's power-good input has until the end of that window to go true. After the window the next rail's step delay runs, and so on. When all four rails are good, a done flag goes high. On power-down the enables drop from rail 3 to rail 0, each followed by its own step delay.

Any fault drops every enable at once and pulls an active-low fault output. A fault is a late or lost power-good, or another device pulling the shared open-drain fault line low. The fault output stays low for at least the hold time. It is released only once the request has been low for the timeout. After release, the controller waits until the shared line reads high before it accepts a new request. The shared line appears as a drive-out signal and a separate sense-in signal. The request, power-good and sense inputs each pass through a two-flop synchronizer.

Top module: `pwr_seq4`

## Requirements
- R1: While reset is high, and on the cycle after it, `en` is 4'b0000, `seq_done` is 0 and `flt_n` is 1.
- R2: `en[0]` is rail 0 and `en[3]` is rail 3. Rail i's step delay is the field `step_dly[16i+15:16i]`. After `up_req` rises, `en[0]` goes high after d0+4 cycles. Enable i (i = 1..3) goes high blank+di+2 cycles after enable i-1 went high. Enables turn on strictly in order, one per cycle at most.
- R3: `seq_done` goes high blank+1 cycles after `en[3]` rises. If a rail's power-good is not true, as seen through the synchronizer, when its blanking window ends, a fault is entered blank+1 cycles after that rail's enable rose.
- R4: Every delay value N makes its state last N+1 cycles, so a value of 0 gives exactly one cycle.
- R5: When `up_req` falls while the rails are all up, `en[3]` and `seq_done` fall 3 cycles later. `en[i-1]` then falls di+1 cycles after `en[i]` fell.
- R6: After `en[0]` falls, the controller waits d0+1 cycles before it accepts a new request. If `up_req` goes high again at once and d0 ≥ 1, `en[0]` rises 2·d0+3 cycles after it fell.
- R7: When a fault is entered, all enables, `seq_done` and `flt_n` go low in the same cycle. When the power-good of an enabled, already-checked rail falls, or when `flt_sense` falls, the fault is entered 3 cycles later.
- R8: `flt_n` stays low for at least hold+1 cycles. If `up_req` has already been low for ud_tmo+3 cycles or more when the hold ends, `flt_n` is low for exactly hold+1 cycles.
- R9: If `up_req` is still high when the hold ends, `flt_n` stays low. It rises ud_tmo+3 cycles after `up_req` falls.
- R10: After the fault is released, the controller starts no power-up while `flt_sense` is low. If `up_req` is high when `flt_sense` returns high, `en[0]` rises d0+5 cycles later.
- R11: A low `up_req` during power-up does not stop the sequence: the remaining enables still rise on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Request: high = rails up, low = rails down (asynchronous) |
| uv_ok | input | 4 | Per-rail power-good, above the under-voltage limit (asynchronous) |
| flt_sense | input | 1 | Sensed level of the shared open-drain fault line (asynchronous) |
| step_dly | input | 64 | Four 16-bit step delays; field i belongs to rail i |
| blank_dly | input | 16 | Blanking window length in cycles, minus one |
| hold_dly | input | 16 | Minimum fault hold length in cycles, minus one |
| ud_tmo | input | 16 | Request-low time needed to release a fault |
| en | output | 4 | Rail enables |
| seq_done | output | 1 | All rails up and good |
| flt_n | output | 1 | Active-low drive onto the shared fault line |

## Verification
The main sequence runs with hand-picked step delays, with every delay at zero, and with eight random sets of delays and blanking lengths. These runs tell apart per-rail delays that are indexed correctly from ones that are swapped or shared, and they show whether a zero count gives one cycle or none. Each fault cause is tried on its own: a blanking window too short for the rail, a rail dropping while done, and the shared line pulled low from outside. Each release path is also tried: a request already low when the hold ends, a request dropped late, and an outside device still holding the line. Together these separate the hold timer, the request-low timeout and the line-sense gate.

// File: rtl/pwr_seq4_pkg.sv
`timescale 1ns/1ps
package pwr_seq4_pkg;
  typedef enum logic [3:0] {
    S_WAIT_START,
    S_PU_DLY,
    S_PU_BLANK,
    S_PU_DONE,
    S_PD_DLY,
    S_SET_FAULT,
    S_CLR_FAULT,
    S_WAIT_ALL_OK
  } seq_state_e;
endpackage

// File: rtl/pwr_seq4_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous inputs.
module pwr_seq4_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_seq4_timer.sv
`timescale 1ns/1ps
// Down counter: load N on state entry, done after N+1 cycles.
module pwr_seq4_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          done
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwr_seq4_lowmon.sv
`timescale 1ns/1ps
// Measures how long the synchronized request has been low.
module pwr_seq4_lowmon #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_s,
  input  logic [DW-1:0] limit,
  output logic          low_long
);
  logic [DW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || up_s)        low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  assign low_long = !up_s && (low_cnt >= limit);
endmodule

// File: rtl/pwr_seq4.sv
`timescale 1ns/1ps
module pwr_seq4
  import pwr_seq4_pkg::*;
#(
  parameter int RAILS = 4,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up_req,
  input  logic [RAILS-1:0]    uv_ok,
  input  logic                flt_sense,
  input  logic [RAILS*DW-1:0] step_dly,
  input  logic [DW-1:0]       blank_dly,
  input  logic [DW-1:0]       hold_dly,
  input  logic [DW-1:0]       ud_tmo,
  output logic [RAILS-1:0]    en,
  output logic                seq_done,
  output logic                flt_n
);
  localparam int IW = (RAILS > 1) ? $clog2(RAILS) : 1;
  localparam logic [IW-1:0] LAST = IW'(RAILS - 1);

  logic             up_s, flt_s;
  logic [RAILS-1:0] uv_s;

  pwr_seq4_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_up (
    .clk(clk), .rst(rst), .d(up_req), .q(up_s));
  pwr_seq4_sync #(.W(RAILS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_uv (
    .clk(clk), .rst(rst), .d(uv_ok), .q(uv_s));
  pwr_seq4_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_flt (
    .clk(clk), .rst(rst), .d(flt_sense), .q(flt_s));

  seq_state_e       st, nxt;
  logic [IW-1:0]    idx, nidx;
  logic [RAILS-1:0] good;
  logic             ld, t_done, ud_ok, go_flt, en_set, en_clr, good_set, uv_lost;
  logic [DW-1:0]    ldv;

  pwr_seq4_timer #(.DW(DW)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ldv), .done(t_done));

  pwr_seq4_lowmon #(.DW(DW)) u_lowmon (
    .clk(clk), .rst(rst), .up_s(up_s), .limit(ud_tmo), .low_long(ud_ok));

  function automatic logic [DW-1:0] step_of(input logic [IW-1:0] i);
    return step_dly[int'(i)*DW +: DW];
  endfunction

  assign uv_lost = |(good & ~uv_s);

  always_comb begin
    nxt      = st;
    nidx     = idx;
    ld       = 1'b0;
    ldv      = '0;
    go_flt   = 1'b0;
    en_set   = 1'b0;
    en_clr   = 1'b0;
    good_set = 1'b0;
    case (st)
      S_WAIT_START: begin
        if (!flt_s) go_flt = 1'b1;
        else if (up_s) begin
          nxt = S_PU_DLY; nidx = '0; ld = 1'b1; ldv = step_of('0);
        end
      end
      S_PU_DLY: begin
        if (!flt_s || uv_lost) go_flt = 1'b1;
        else if (t_done) begin
          nxt = S_PU_BLANK; ld = 1'b1; ldv = blank_dly; en_set = 1'b1;
        end
      end
      S_PU_BLANK: begin
        if (!flt_s || uv_lost) go_flt = 1'b1;
        else if (t_done) begin
          if (!uv_s[idx]) go_flt = 1'b1;
          else begin
            good_set = 1'b1;
            if (idx == LAST) nxt = S_PU_DONE;
            else begin
              nidx = idx + 1'b1; nxt = S_PU_DLY; ld = 1'b1; ldv = step_of(idx + 1'b1);
            end
          end
        end
      end
      S_PU_DONE: begin
        if (!flt_s || uv_lost) go_flt = 1'b1;
        else if (!up_s) begin
          nxt = S_PD_DLY; nidx = LAST; ld = 1'b1; ldv = step_of(LAST); en_clr = 1'b1;
        end
      end
      S_PD_DLY: begin
        if (!flt_s) go_flt = 1'b1;
        else if (t_done) begin
          if (idx == '0) nxt = S_WAIT_START;
          else begin
            nidx = idx - 1'b1; ld = 1'b1; ldv = step_of(idx - 1'b1); en_clr = 1'b1;
          end
        end
      end
      S_SET_FAULT:   if (t_done) nxt = ud_ok ? S_WAIT_ALL_OK : S_CLR_FAULT;
      S_CLR_FAULT:   if (ud_ok) nxt = S_WAIT_ALL_OK;
      S_WAIT_ALL_OK: if (flt_s) nxt = S_WAIT_START;
      default:       nxt = S_WAIT_START;
    endcase
    if (go_flt) begin
      nxt = S_SET_FAULT; ld = 1'b1; ldv = hold_dly;
      en_set = 1'b0; en_clr = 1'b0; good_set = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_WAIT_START;
      idx      <= '0;
      good     <= '0;
      en       <= '0;
      seq_done <= 1'b0;
      flt_n    <= 1'b1;
    end else begin
      st  <= nxt;
      idx <= nidx;
      if (nxt == S_SET_FAULT)      en <= '0;
      else if (en_set)             en[idx] <= 1'b1;
      else if (en_clr)             en[nidx] <= 1'b0;
      if (nxt == S_SET_FAULT || nxt == S_PD_DLY) good <= '0;
      else if (good_set)                         good[idx] <= 1'b1;
      seq_done <= (nxt == S_PU_DONE);
      flt_n    <= !(nxt == S_SET_FAULT || nxt == S_CLR_FAULT);
    end
  end
endmodule

// File: rtl/pwr_seq4_chk.sv
`timescale 1ns/1ps
module pwr_seq4_chk #(
  parameter int RAILS = 4,
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [RAILS-1:0] en,
  input logic             seq_done,
  input logic             flt_n,
  input logic [DW-1:0]    hold_dly
);
  logic [DW:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || flt_n)          low_cnt <= '0;
    else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
  end

  // R2
  en_order_chk: assert property (@(posedge clk) disable iff (rst)
    (en & (en + 1'b1)) == '0);

  // R2
  en_rise_one_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(en & ~$past(en)) <= 1);

  // R5
  en_fall_one_chk: assert property (@(posedge clk) disable iff (rst)
    flt_n |-> $countones(~en & $past(en)) <= 1);

  // R3
  done_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (&en));

  // R7
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_n |-> (en == '0) && !seq_done);

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_n) |-> (low_cnt >= ({1'b0, hold_dly} + 1'b1)));
endmodule

bind pwr_seq4 pwr_seq4_chk #(.RAILS(RAILS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .seq_done(seq_done),
  .flt_n(flt_n), .hold_dly(hold_dly));

// File: tb/pwr_seq4_tb.sv
`timescale 1ns/1ps
module pwr_seq4_tb;
  logic        clk = 1'b0, rst = 1'b1, up_req = 1'b0, ext_n = 1'b1;
  logic [3:0]  kill = 4'b0;
  logic [63:0] step_dly = '0;
  logic [15:0] blank_dly = 16'd4, hold_dly = 16'd10, ud_tmo = 16'd4;
  logic [3:0]  en, uv_ok;
  logic        seq_done, flt_n, flt_line;

  assign uv_ok    = en & ~kill;
  assign flt_line = flt_n & ext_n;

  pwr_seq4 u_dut (
    .clk(clk), .rst(rst), .up_req(up_req), .uv_ok(uv_ok), .flt_sense(flt_line),
    .step_dly(step_dly), .blank_dly(blank_dly), .hold_dly(hold_dly), .ud_tmo(ud_tmo),
    .en(en), .seq_done(seq_done), .flt_n(flt_n));

  always #2 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int n_chk = 0, n_fail = 0;
  int dv [4];
  int bv;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    if (sel < 4) return en[sel];
    if (sel == 4) return seq_done;
    return flt_n;
  endfunction

  task automatic wait_sig(input string req, input int sel, input logic v, output longint t);
    int k = 0;
    while (sig(sel) !== v && k < 3000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 3000) chk({req, " timeout"}, 0, 1);
    t = cyc;
  endtask

  task automatic set_dly(input int a0, input int a1, input int a2, input int a3, input int b);
    dv[0] = a0; dv[1] = a1; dv[2] = a2; dv[3] = a3; bv = b;
    step_dly  = {16'(a3), 16'(a2), 16'(a1), 16'(a0)};
    blank_dly = 16'(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    longint t0, t, tp;
    t0 = cyc; up_req = 1'b1;
    wait_sig("R2", 0, 1'b1, t);
    chk("R2 first enable", t - t0, dv[0] + 4);
    for (int i = 1; i < 4; i++) begin
      tp = t;
      wait_sig("R2", i, 1'b1, t);
      chk("R2 enable gap", t - tp, bv + dv[i] + 2);
    end
    tp = t;
    wait_sig("R3", 4, 1'b1, t);
    chk("R3 done after blank", t - tp, bv + 1);
  endtask

  task automatic power_down();
    longint t0, t, tp;
    t0 = cyc; up_req = 1'b0;
    wait_sig("R5", 3, 1'b0, t);
    chk("R5 top rail off", t - t0, 3);
    chk("R5 done low", seq_done, 0);
    for (int i = 2; i >= 0; i--) begin
      tp = t;
      wait_sig("R5", i, 1'b0, t);
      chk("R5 disable gap", t - tp, dv[i+1] + 1);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    longint t, t0, tf;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 en", en, 0);
    chk("R1 seq_done", seq_done, 0);
    chk("R1 flt_n", flt_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 en after release", en, 0);
    chk("R1 flt_n after release", flt_n, 1);

    // R2 R3 R5 directed
    set_dly(3, 0, 5, 1, 4);
    power_up();
    power_down();
    idle(10);

    // R4 all zero delays
    set_dly(0, 0, 0, 0, 2);
    t0 = cyc; up_req = 1'b1;
    wait_sig("R4", 0, 1'b1, t);
    chk("R4 zero delay one cycle", t - t0, 4);
    t0 = t;
    wait_sig("R4", 1, 1'b1, t);
    chk("R4 zero step gap", t - t0, 4);
    wait_sig("R4", 4, 1'b1, t);
    power_down();
    idle(10);

    // R6 trailing delay and immediate restart
    set_dly(6, 2, 1, 3, 3);
    power_up();
    t0 = cyc; up_req = 1'b0;
    wait_sig("R6", 0, 1'b0, t);
    up_req = 1'b1;
    wait_sig("R6", 0, 1'b1, tf);
    chk("R6 trailing delay then restart", tf - t, 2 * dv[0] + 3);
    wait_sig("R6", 4, 1'b1, t);
    power_down();
    idle(12);

    // constrained random sequences (R2 R3 R5)
    for (int it = 0; it < 8; it++) begin
      set_dly($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12),
              $urandom_range(0, 12), $urandom_range(2, 10));
      power_up();
      power_down();
      idle(dv[0] + 5);
    end

    // R3 blanking too short: fault at window end
    set_dly(2, 2, 2, 2, 1);
    up_req = 1'b1;
    wait_sig("R3", 0, 1'b1, t0);
    wait_sig("R3", 5, 1'b0, tf);
    chk("R3 late power-good fault", tf - t0, bv + 1);
    chk("R7 enables dropped", en, 0);
    up_req = 1'b0;
    wait_sig("R3", 5, 1'b1, t);
    idle(10);

    // R8 R11 straight release with request already low
    set_dly(1, 2, 3, 4, 4);
    hold_dly = 16'd10; ud_tmo = 16'd4;
    kill = 4'b1000;
    up_req = 1'b1;
    wait_sig("R11", 2, 1'b1, t0);
    up_req = 1'b0;
    wait_sig("R11", 3, 1'b1, t);
    chk("R11 sequence continues with request low", t - t0, bv + dv[3] + 2);
    chk("R11 lower rails still on", en, 4'hF);
    wait_sig("R8", 5, 1'b0, tf);
    chk("R3 missing rail faults", tf - t, bv + 1);
    chk("R7 enables dropped", en, 0);
    chk("R7 done dropped", seq_done, 0);
    wait_sig("R8", 5, 1'b1, t);
    chk("R8 minimum hold width", t - tf, hold_dly + 1);
    kill = 4'b0;
    idle(10);

    // R9 extended hold
    set_dly(2, 2, 2, 2, 3);
    kill = 4'b0010;
    up_req = 1'b1;
    wait_sig("R9", 5, 1'b0, tf);
    idle(40);
    chk("R9 fault held while request high", flt_n, 0);
    t0 = cyc; up_req = 1'b0;
    wait_sig("R9", 5, 1'b1, t);
    chk("R9 release after request-low timeout", t - t0, ud_tmo + 3);
    kill = 4'b0;
    idle(10);

    // R7 R10 external fault via shared line
    set_dly(4, 1, 1, 1, 3);
    power_up();
    t0 = cyc; ext_n = 1'b0;
    wait_sig("R7", 3, 1'b0, t);
    chk("R7 external fault latency", t - t0, 3);
    chk("R7 all enables off", en, 0);
    chk("R7 fault driven", flt_n, 0);
    up_req = 1'b0;
    wait_sig("R10", 5, 1'b1, t);
    up_req = 1'b1;
    idle(40);
    chk("R10 no start while line held low", en, 0);
    t0 = cyc; ext_n = 1'b1;
    wait_sig("R10", 0, 1'b1, t);
    chk("R10 start after line release", t - t0, dv[0] + 5);
    wait_sig("R10", 4, 1'b1, t);

    // R7 lost power-good while done
    t0 = cyc; kill = 4'b0100;
    wait_sig("R7", 5, 1'b0, t);
    chk("R7 lost power-good latency", t - t0, 3);
    chk("R7 enables dropped on loss", en, 0);
    up_req = 1'b0;
    wait_sig("R7", 5, 1'b1, t);
    kill = 4'b0;
    idle(10);
    chk("R1 idle after recovery", en, 0);

    finish_up();
  end
endmodule